// File: doc/BRIEF.md
# I2C Bus Timing Compliance Monitor

This block watches the clock and data wires of a two-wire serial bus without driving them. It never holds the clock low. Each wire passes through a two-flop synchronizer. The block then finds the edges and recognises the bus events: START, repeated START, STOP and data bits. Three saturating counters measure the time between these events in system-clock cycles. Each interval is compared against the minimum that applies to the bus speed selected.

When an interval is too short, the monitor raises a one-cycle strobe. A 3-bit code with the strobe names the rule that was broken. The strobe appears in the cycle where the closing edge is seen on the synchronized lines. Every limit is derived from the `CLK_HZ` parameter, rounded up to whole cycles. The `fast_mode` input chooses between the 100 kHz-class and 400 kHz-class limit sets. A synchronous reset puts the monitor in the bus-idle state, where it waits for a START.

Top module: `i2c_timing_monitor`

## Requirements
- R1: While reset is high, and in the cycle after it, the strobe is low. After reset the bus counts as idle, so the first START is not checked against the bus-free minimum.
- R2: Clock low time. When a clock rise follows a clock fall by fewer cycles than the low minimum (4.7 us standard, 1.3 us fast), the strobe fires with code 1.
- R3: Clock high time. When a clock fall follows a clock rise by fewer cycles than the high minimum (4 us standard, 0.6 us fast), the strobe fires with code 2.
- R4: Clock period. When two clock rises are closer than the period minimum (10 us standard, 2.5 us fast), the strobe fires with code 3. If the same edge also breaks R2, only code 1 is reported.
- R5: START hold. On the first clock fall after a START or repeated START, if the fall comes fewer than 4 us (standard) or 0.6 us (fast) after the data fall, the strobe fires with code 4. Code 4 takes priority over code 2.
- R6: Repeated START setup. A data fall with the clock high while a transfer is open is a repeated START. If it comes fewer than 4.7 us (standard) or 0.6 us (fast) after the clock rise, the strobe fires with code 5.
- R7: STOP setup. A data rise with the clock high during a transfer is a STOP. If it comes fewer than 4 us (standard) or 0.6 us (fast) after the clock rise, the strobe fires with code 6.
- R8: Bus free time. If a START on an idle bus comes fewer than 4.7 us (standard) or 1.3 us (fast) after the preceding STOP, the strobe fires with code 7.
- R9: Data setup. This check applies only when data changed while the clock was low. If the clock rises fewer than 250 ns (standard) or 100 ns (fast) after that change, the strobe fires with code 0. A data change in the same cycle as the clock rise is also a violation. On a single clock rise, the order of precedence is code 1, then code 3, then code 0.
- R10: Each limit equals ceil(time x CLK_HZ / 1e9) cycles. `fast_mode` = 1 selects the fast set and `fast_mode` = 0 the standard set. An interval exactly equal to its limit passes.
- R11: Clock toggling on an idle bus (no START) raises no strobe. Each violating edge gives exactly one single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fast_mode | input | 1 | 1 selects fast limits, 0 selects standard limits |
| scl_in | input | 1 | Bus clock wire, asynchronous |
| sda_in | input | 1 | Bus data wire, asynchronous |
| viol_valid | output | 1 | One-cycle violation strobe |
| viol_code | output | 3 | Broken rule, valid while strobe is high |

## Verification
The bench builds the monitor with `CLK_HZ` = 10 MHz. At that value every limit is a small number of cycles: 47, 40, 100, 3 and so on for the standard set, and 13, 6, 25, 1 for the fast set. Transfers can therefore be driven with intervals placed exactly at a limit and one cycle below it, in both modes, within a short run. This brings the rounding, the priority between rules on a shared edge, and the same-cycle data change within reach.

// File: rtl/i2c_timing_monitor.sv
module i2c_timing_monitor #(
  parameter longint CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fast_mode,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       viol_valid,
  output logic [2:0] viol_code
);

  function automatic longint ns2cyc(input longint ns);
    return (ns * CLK_HZ + longint'(999_999_999)) / longint'(1_000_000_000);
  endfunction

  localparam longint LIM_MAX = ns2cyc(10_000);
  localparam int     CW      = $clog2(LIM_MAX + 1) + 1;
  localparam logic [CW-1:0] SAT = '1;

  localparam logic [CW-1:0] S_LOW  = CW'(ns2cyc(4700));
  localparam logic [CW-1:0] F_LOW  = CW'(ns2cyc(1300));
  localparam logic [CW-1:0] S_HIGH = CW'(ns2cyc(4000));
  localparam logic [CW-1:0] F_HIGH = CW'(ns2cyc(600));
  localparam logic [CW-1:0] S_PER  = CW'(ns2cyc(10_000));
  localparam logic [CW-1:0] F_PER  = CW'(ns2cyc(2500));
  localparam logic [CW-1:0] S_HOLD = CW'(ns2cyc(4000));
  localparam logic [CW-1:0] F_HOLD = CW'(ns2cyc(600));
  localparam logic [CW-1:0] S_RSU  = CW'(ns2cyc(4700));
  localparam logic [CW-1:0] F_RSU  = CW'(ns2cyc(600));
  localparam logic [CW-1:0] S_PSU  = CW'(ns2cyc(4000));
  localparam logic [CW-1:0] F_PSU  = CW'(ns2cyc(600));
  localparam logic [CW-1:0] S_FREE = CW'(ns2cyc(4700));
  localparam logic [CW-1:0] F_FREE = CW'(ns2cyc(1300));
  localparam logic [CW-1:0] S_SU   = CW'(ns2cyc(250));
  localparam logic [CW-1:0] F_SU   = CW'(ns2cyc(100));

  localparam logic [2:0] C_SETUP  = 3'd0;
  localparam logic [2:0] C_LOW    = 3'd1;
  localparam logic [2:0] C_HIGH   = 3'd2;
  localparam logic [2:0] C_PER    = 3'd3;
  localparam logic [2:0] C_HOLD   = 3'd4;
  localparam logic [2:0] C_RSU    = 3'd5;
  localparam logic [2:0] C_PSU    = 3'd6;
  localparam logic [2:0] C_FREE   = 3'd7;

  // two-flop synchronizers plus one stage of history for edge detection
  logic [1:0] scl_sy, sda_sy;
  logic       scl_p, sda_p;
  logic       scl_s, sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_p  <= scl_sy[1];
      sda_p  <= sda_sy[1];
    end
  end

  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  logic scl_r, scl_f, sda_e, start_ev, stop_ev;
  assign scl_r    =  scl_s & ~scl_p;
  assign scl_f    = ~scl_s &  scl_p;
  assign sda_e    =  sda_s ^  sda_p;
  assign start_ev = ~sda_s &  sda_p & scl_s & scl_p;
  assign stop_ev  =  sda_s & ~sda_p & scl_s & scl_p;

  logic [CW-1:0] lim_low, lim_high, lim_per, lim_hold, lim_rsu, lim_psu, lim_free, lim_su;
  assign lim_low  = fast_mode ? F_LOW  : S_LOW;
  assign lim_high = fast_mode ? F_HIGH : S_HIGH;
  assign lim_per  = fast_mode ? F_PER  : S_PER;
  assign lim_hold = fast_mode ? F_HOLD : S_HOLD;
  assign lim_rsu  = fast_mode ? F_RSU  : S_RSU;
  assign lim_psu  = fast_mode ? F_PSU  : S_PSU;
  assign lim_free = fast_mode ? F_FREE : S_FREE;
  assign lim_su   = fast_mode ? F_SU   : S_SU;

  // elapsed cycles since the last clock fall, clock rise and data edge
  logic [CW-1:0] t_fall, t_rise, t_sda;
  logic          busy, after_start, seen_stop, sda_low_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      t_fall      <= SAT;
      t_rise      <= SAT;
      t_sda       <= SAT;
      busy        <= 1'b0;
      after_start <= 1'b0;
      seen_stop   <= 1'b0;
      sda_low_chg <= 1'b0;
    end else begin
      t_fall <= scl_f ? CW'(1) : (t_fall == SAT ? SAT : t_fall + 1'b1);
      t_rise <= scl_r ? CW'(1) : (t_rise == SAT ? SAT : t_rise + 1'b1);
      t_sda  <= sda_e ? CW'(1) : (t_sda  == SAT ? SAT : t_sda  + 1'b1);
      if (start_ev)     busy <= 1'b1;
      else if (stop_ev) busy <= 1'b0;
      if (start_ev)     after_start <= 1'b1;
      else if (scl_f)   after_start <= 1'b0;
      if (stop_ev)      seen_stop <= 1'b1;
      if (scl_r || start_ev)   sda_low_chg <= 1'b0;
      else if (sda_e && !scl_s) sda_low_chg <= 1'b1;
    end
  end

  always_comb begin
    viol_valid = 1'b0;
    viol_code  = C_SETUP;
    if (start_ev) begin
      if (busy) begin
        if (t_rise < lim_rsu) begin viol_valid = 1'b1; viol_code = C_RSU; end
      end else if (seen_stop && t_sda < lim_free) begin
        viol_valid = 1'b1; viol_code = C_FREE;
      end
    end else if (stop_ev && busy) begin
      if (t_rise < lim_psu) begin viol_valid = 1'b1; viol_code = C_PSU; end
    end else if (scl_f && busy) begin
      if (after_start && t_sda < lim_hold) begin viol_valid = 1'b1; viol_code = C_HOLD; end
      else if (t_rise < lim_high)          begin viol_valid = 1'b1; viol_code = C_HIGH; end
    end else if (scl_r && busy) begin
      if (t_fall < lim_low)                          begin viol_valid = 1'b1; viol_code = C_LOW; end
      else if (t_rise < lim_per)                     begin viol_valid = 1'b1; viol_code = C_PER; end
      else if (sda_e || (sda_low_chg && t_sda < lim_su)) begin viol_valid = 1'b1; viol_code = C_SETUP; end
    end
  end

endmodule

// File: rtl/i2c_timing_monitor_chk.sv
module i2c_timing_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       viol_valid,
  input logic [2:0] viol_code,
  input logic       scl_s,
  input logic       scl_p,
  input logic       sda_s,
  input logic       sda_p,
  input logic       busy
);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !viol_valid);

  p_low_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && viol_code == 3'd1) |-> (scl_s && !scl_p));

  p_high_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && viol_code == 3'd2) |-> (!scl_s && scl_p));

  p_period_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && viol_code == 3'd3) |-> (scl_s && !scl_p));

  p_hold_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && viol_code == 3'd4) |-> (!scl_s && scl_p && busy));

  p_rstart_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && viol_code == 3'd5) |-> (busy && scl_s && scl_p && !sda_s && sda_p));

  p_stop_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && viol_code == 3'd6) |=> !busy);

  p_free_opens_r8: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && viol_code == 3'd7) |-> !busy ##1 busy);

  p_setup_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && viol_code == 3'd0) |-> (scl_s && !scl_p));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(scl_s && scl_p && !sda_s && sda_p)) |-> !viol_valid);

endmodule

bind i2c_timing_monitor i2c_timing_monitor_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .viol_valid (viol_valid),
  .viol_code  (viol_code),
  .scl_s      (scl_s),
  .scl_p      (scl_p),
  .sda_s      (sda_s),
  .sda_p      (sda_p),
  .busy       (busy)
);

// File: tb/i2c_timing_monitor_tb.sv
module i2c_timing_monitor_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fast_mode = 1'b0;
  logic       scl_in = 1'b1;
  logic       sda_in = 1'b1;
  logic       viol_valid;
  logic [2:0] viol_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [2:0] exp_code[$];
  string      exp_tag[$];

  always #10 clk = ~clk;

  i2c_timing_monitor #(.CLK_HZ(10_000_000)) u_dut (
    .clk(clk), .rst(rst), .fast_mode(fast_mode),
    .scl_in(scl_in), .sda_in(sda_in),
    .viol_valid(viol_valid), .viol_code(viol_code)
  );

  task automatic push(input logic [2:0] c, input string tag);
    exp_code.push_back(c);
    exp_tag.push_back(tag);
  endtask

  task automatic seg(input logic s, input logic d, input int n);
    scl_in = s;
    sda_in = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_start(input int h);
    seg(1'b1, 1'b0, h);
  endtask

  task automatic t_bit(input logic b, input int a, input int su, input int hi);
    seg(1'b0, sda_in, a);
    seg(1'b0, b, su);
    seg(1'b1, b, hi);
  endtask

  task automatic t_stop(input int a, input int su, input int hi);
    seg(1'b0, sda_in, a);
    seg(1'b0, 1'b0, su);
    seg(1'b1, 1'b0, hi);
    sda_in = 1'b1;
  endtask

  task automatic t_rstart(input int a, input int su, input int hi, input int h);
    seg(1'b0, sda_in, a);
    seg(1'b0, 1'b1, su);
    seg(1'b1, 1'b1, hi);
    seg(1'b1, 1'b0, h);
  endtask

  task automatic t_idle(input int n);
    seg(1'b1, 1'b1, n);
  endtask

  task automatic drained(input string tag);
    repeat (6) @(negedge clk);
    checks++;
    if (exp_code.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d expected violations missing (actual %0d, expected 0)",
               tag, exp_code.size(), exp_code.size());
      exp_code.delete();
      exp_tag.delete();
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && viol_valid) begin
      checks++;
      if (exp_code.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected strobe, actual code %0d, expected none", viol_code);
      end else begin
        logic [2:0] e;
        string t;
        e = exp_code.pop_front();
        t = exp_tag.pop_front();
        if (viol_code !== e) begin
          errors++;
          $display("FAIL %s: actual code %0d, expected %0d", t, viol_code, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150_000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (viol_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: strobe in reset, actual %b expected 0", viol_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (viol_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: strobe after reset, actual %b expected 0", viol_valid);
    end

    // R1: clean standard transfer, first START right after reset
    t_idle(5);
    t_start(45);
    t_bit(1'b1, 10, 40, 50);
    t_bit(1'b0, 10, 40, 50);
    t_bit(1'b1, 10, 40, 50);
    t_stop(10, 40, 50);
    t_idle(60);
    drained("R1");

    // R5: START hold 30 < 40
    push(3'd4, "R5");
    t_start(30);
    t_bit(1'b0, 10, 40, 50);
    drained("R5");

    // R2 and R4 priority: low 40 < 47, period 90 also short
    push(3'd1, "R2");
    t_bit(1'b1, 10, 30, 60);
    drained("R2");

    // R4: low 50 ok, period 45 + 50 = 95 < 100
    t_bit(1'b0, 7, 40, 45);
    push(3'd3, "R4");
    t_bit(1'b0, 10, 40, 50);
    drained("R4");

    // R3: high 30 < 40
    t_bit(1'b1, 10, 40, 30);
    push(3'd2, "R3");
    t_bit(1'b1, 30, 40, 50);
    drained("R3");

    // R9: setup 2 < 3, then same-cycle change, then setup exactly 3 passes (R10)
    push(3'd0, "R9");
    t_bit(1'b0, 51, 2, 50);
    push(3'd0, "R9");
    t_bit(1'b1, 50, 0, 50);
    t_bit(1'b0, 47, 3, 50);
    drained("R9");

    // R6: repeated START setup 20 < 47
    push(3'd5, "R6");
    t_rstart(10, 40, 20, 45);
    t_bit(1'b1, 10, 40, 50);
    drained("R6");

    // R7: STOP setup 20 < 40
    push(3'd6, "R7");
    t_stop(10, 40, 20);
    t_idle(60);
    drained("R7");

    // R8: bus free 20 < 47
    t_start(45);
    t_bit(1'b0, 10, 40, 50);
    t_stop(10, 40, 50);
    t_idle(20);
    push(3'd7, "R8");
    t_start(45);
    t_bit(1'b1, 10, 40, 50);
    t_stop(10, 40, 50);
    t_idle(60);
    drained("R8");

    // R11: clock toggling on an idle bus
    for (int i = 0; i < 5; i++) begin
      seg(1'b0, 1'b1, 2);
      seg(1'b1, 1'b1, 2);
    end
    t_idle(60);
    drained("R11");

    // R10: fast limits, intervals exactly at each fast minimum
    fast_mode = 1'b1;
    t_idle(20);
    t_start(6);
    t_bit(1'b1, 3, 10, 12);
    t_bit(1'b0, 3, 10, 12);
    t_stop(3, 10, 6);
    t_idle(13);
    t_start(6);
    t_bit(1'b0, 3, 10, 12);
    drained("R10");

    // R10 with R2: fast low 12 < 13
    push(3'd1, "R10");
    t_bit(1'b1, 2, 10, 13);
    drained("R10");

    // R10 with R9: fast same-cycle data change
    t_bit(1'b1, 3, 10, 12);
    push(3'd0, "R10");
    t_bit(1'b0, 13, 0, 12);
    t_stop(3, 10, 6);
    t_idle(20);
    drained("R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule